// File: doc/BRIEF.md
# Timer Synchronization and Register Update Control

This block is the control slice that sits beside a timer counter. It watches an external synchronization event and decides, under two independent enables, whether that event starts a counter that is idle or restarts a counter that is already counting. It emits a one-cycle start strobe or reset strobe for the counter datapath, which lives outside the block.

The block also decides when the timer's preloaded shadow registers are copied into the active registers. Update requests come from a set of neighbouring timers and from software. A resynchronize bit chooses between two timings. In the first, a request produces a transfer straight away. In the second, the request is parked in a single pending flag and released at the next period boundary. A period boundary is either a rollover of the counter or a counter reset caused by the sync event. The resynchronize bit takes effect only while the 4-bit update gating field is all zeros. Any other gating value makes every request immediate.

All three strobes are registered. Each appears on the clock edge that samples its cause and lasts one cycle.

Top module: `tmr_sync_upd_ctrl`

## Requirements
- R1: A sync event with the start enable set while the counter is idle (`cnt_running_i`=0) raises `cnt_start_o` for exactly the next cycle. With the start enable clear, the event raises no start.
- R2: A sync event with the reset enable set while the counter is running (`cnt_running_i`=1) raises `cnt_reset_o` for exactly the next cycle. With the reset enable clear, the event raises no reset.
- R3: A sync event never starts a running counter and never resets an idle one, so `cnt_start_o` and `cnt_reset_o` are never high together, even with both enables set.
- R4: With the resynchronize bit clear and the gating field 4'b0000, any neighbour request bit or the software request raises `xfer_o` in the next cycle.
- R5: With the resynchronize bit set and the gating field 4'b0000, a request raises no transfer until a period boundary. `xfer_o` then rises in the cycle after the `rollover_i` strobe.
- R6: With any nonzero gating field, the resynchronize bit is ignored and every request is applied as in R4.
- R7: Any number of deferred requests before one boundary produce a single one-cycle `xfer_o` pulse at that boundary.
- R8: A sync reset counts as a period boundary. A pending deferred update is transferred in the same cycle that `cnt_reset_o` is high.
- R9: A deferred request that arrives in the same cycle as a boundary is applied at that boundary and is not kept pending.
- R10: While `rst_n` is low, all outputs are low and the pending flag is cleared, so a boundary after reset release with no new request gives no transfer.
- R11: A boundary with nothing pending produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_evt_i | input | 1 | External synchronization event strobe |
| sync_start_en_i | input | 1 | Allow a sync event to start an idle counter |
| sync_reset_en_i | input | 1 | Allow a sync event to reset a running counter |
| cnt_running_i | input | 1 | Counter is currently enabled and counting |
| rollover_i | input | 1 | Counter rollover/reset strobe (period boundary) |
| gate_mode_i | input | 4 | Update gating field; resynchronize bit honoured only at 4'b0000 |
| resync_en_i | input | 1 | Defer neighbour and software updates to the next boundary |
| nbr_upd_i | input | 7 | Update requests from neighbouring timers |
| sw_upd_i | input | 1 | Software update request |
| cnt_start_o | output | 1 | One-cycle counter start strobe |
| cnt_reset_o | output | 1 | One-cycle counter reset strobe |
| xfer_o | output | 1 | One-cycle shadow-to-active transfer strobe |

## Verification
The only hidden state is the pending-update flag. If it is wrong, nothing shows until the next boundary. A flag that is stuck high gives a spurious `xfer_o` the cycle after the next `rollover_i` or sync reset. A flag that is lost gives a missing pulse at that same point. The sync and immediate paths hold no memory, so any fault there appears on the strobe one cycle after the stimulus. A reference model that is compared on every clock catches both kinds of fault at the first boundary that follows.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int unsigned GATE_W = 4;
  typedef logic [GATE_W-1:0] gate_t;

  // deferral is only honoured when update gating is off
  function automatic logic defer_active(input gate_t gate, input logic resync);
    return resync && (gate == '0);
  endfunction
endpackage

// File: rtl/tsu_sync_decode.sv
module tsu_sync_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt_i,
  input  logic start_en_i,
  input  logic reset_en_i,
  input  logic running_i,
  output logic reset_fire_o,
  output logic start_q_o,
  output logic reset_q_o
);
  logic start_fire;
  logic start_d, reset_d;

  // next-state: an event starts an idle counter or restarts a running one
  always_comb begin
    start_fire   = sync_evt_i && start_en_i && !running_i;
    reset_fire_o = sync_evt_i && reset_en_i && running_i;
    start_d      = start_fire;
    reset_d      = reset_fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q_o <= 1'b0;
      reset_q_o <= 1'b0;
    end else begin
      start_q_o <= start_d;
      reset_q_o <= reset_d;
    end
  end

  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_q_o |-> $past(sync_evt_i && start_en_i));
  assert_reset_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_q_o |-> $past(sync_evt_i && reset_en_i));
  assert_start_reset_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q_o && reset_q_o));
endmodule

// File: rtl/tsu_req_merge.sv
module tsu_req_merge #(
  parameter int unsigned N_NBR = 7
) (
  input  logic [N_NBR-1:0] nbr_req_i,
  input  logic             sw_req_i,
  output logic             any_req_o
);
  logic [N_NBR:0] chain;

  assign chain[0] = sw_req_i;
  for (genvar g = 0; g < N_NBR; g++) begin : g_or
    assign chain[g+1] = chain[g] | nbr_req_i[g];
  end
  assign any_req_o = chain[N_NBR];
endmodule

// File: rtl/tsu_upd_defer.sv
module tsu_upd_defer
  import tsu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_i,
  input  logic  resync_i,
  input  gate_t gate_i,
  input  logic  rollover_i,
  input  logic  sync_rst_i,
  output logic  xfer_o
);
  logic defer, boundary;
  logic pend_q, pend_d;
  logic xfer_d;
  logic pend_en;

  always_comb begin
    defer    = defer_active(gate_i, resync_i);
    boundary = rollover_i || sync_rst_i;
    xfer_d   = 1'b0;
    pend_d   = pend_q;
    if (req_i && !defer) xfer_d = 1'b1;
    if (boundary) begin
      if (pend_q || (req_i && defer)) xfer_d = 1'b1;
      pend_d = 1'b0;
    end else if (req_i && defer) begin
      pend_d = 1'b1;
    end
    pend_en = boundary || (req_i && defer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_o <= 1'b0;
    else        xfer_o <= xfer_d;
  end

  assert_boundary_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover_i || sync_rst_i) |=> !pend_q);
  assert_pending_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (rollover_i || sync_rst_i)) |=> xfer_o);
  assert_idle_no_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i && !pend_q) |=> !xfer_o);
  assert_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && gate_i != '0) |=> xfer_o);
endmodule

// File: rtl/tmr_sync_upd_ctrl.sv
module tmr_sync_upd_ctrl
  import tsu_pkg::*;
#(
  parameter int unsigned N_NBR = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_evt_i,
  input  logic             sync_start_en_i,
  input  logic             sync_reset_en_i,
  input  logic             cnt_running_i,
  input  logic             rollover_i,
  input  logic [GATE_W-1:0] gate_mode_i,
  input  logic             resync_en_i,
  input  logic [N_NBR-1:0] nbr_upd_i,
  input  logic             sw_upd_i,
  output logic             cnt_start_o,
  output logic             cnt_reset_o,
  output logic             xfer_o
);
  logic sync_rst_fire;
  logic any_req;

  tsu_sync_decode u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_evt_i   (sync_evt_i),
    .start_en_i   (sync_start_en_i),
    .reset_en_i   (sync_reset_en_i),
    .running_i    (cnt_running_i),
    .reset_fire_o (sync_rst_fire),
    .start_q_o    (cnt_start_o),
    .reset_q_o    (cnt_reset_o)
  );

  tsu_req_merge #(.N_NBR(N_NBR)) u_merge (
    .nbr_req_i (nbr_upd_i),
    .sw_req_i  (sw_upd_i),
    .any_req_o (any_req)
  );

  tsu_upd_defer u_defer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (any_req),
    .resync_i   (resync_en_i),
    .gate_i     (gate_mode_i),
    .rollover_i (rollover_i),
    .sync_rst_i (sync_rst_fire),
    .xfer_o     (xfer_o)
  );

  assert_reset_carries_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_reset_o && $past(u_defer.pend_q)) |-> xfer_o);
endmodule

// File: tb/tmr_sync_upd_ctrl_bench.sv
module tmr_sync_upd_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 0, sen = 0, ren = 0, run = 0, roll = 0, rsy = 0, sw = 0;
  logic [3:0] gate = 4'd0;
  logic [6:0] nbr = 7'd0;
  logic       st_o, rs_o, xf_o;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R10";

  // reference state
  bit m_pend = 0, e_st = 0, e_rs = 0, e_xf = 0;

  tmr_sync_upd_ctrl u_tmr_sync_upd_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_evt_i(evt), .sync_start_en_i(sen),
    .sync_reset_en_i(ren), .cnt_running_i(run), .rollover_i(roll),
    .gate_mode_i(gate), .resync_en_i(rsy), .nbr_upd_i(nbr), .sw_upd_i(sw),
    .cnt_start_o(st_o), .cnt_reset_o(rs_o), .xfer_o(xf_o));

  always #10 clk = ~clk;

  task automatic chk(input logic got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic cycle();
    bit req, deferring, bnd;
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_pend = 0; e_st = 0; e_rs = 0; e_xf = 0;
    end else begin
      req = (nbr != 0) || sw;
      deferring = rsy && (gate == 4'd0);
      e_st = evt && sen && !run;
      e_rs = evt && ren && run;
      bnd = roll || e_rs;
      e_xf = 0;
      if (req && !deferring) e_xf = 1;
      if (bnd) begin
        if (m_pend || (req && deferring)) e_xf = 1;
        m_pend = 0;
      end else if (req && deferring) m_pend = 1;
    end
    @(negedge clk);
    chk(st_o, e_st, "cnt_start_o");
    chk(rs_o, e_rs, "cnt_reset_o");
    chk(xf_o, e_xf, "xfer_o");
    checks++;
    if (st_o && rs_o) begin
      errors++;
      $display("FAIL R3 start and reset together got 1 exp 0");
    end
  endtask

  task automatic clear_pulses();
    evt = 0; roll = 0; sw = 0; nbr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin clear_pulses(); cycle(); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got 1 exp 0");
    finish_run();
  end

  initial begin : stim
    bit [15:0] lfsr;
    @(negedge clk);
    // R10: reset state
    tag = "R10";
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1: start of idle counter
    tag = "R1";
    sen = 1; run = 0; evt = 1; cycle(); idle(1);
    sen = 0; evt = 1; cycle(); idle(1);
    // R2: reset of running counter
    tag = "R2";
    run = 1; ren = 1; evt = 1; cycle(); idle(1);
    ren = 0; evt = 1; cycle(); idle(1);
    // R3: both enables
    tag = "R3";
    sen = 1; ren = 1; run = 0; evt = 1; cycle();
    run = 1; evt = 1; cycle(); idle(1);
    sen = 0; ren = 0;

    // R4: immediate
    tag = "R4";
    rsy = 0; gate = 0; nbr = 7'b0001000; cycle();
    clear_pulses(); sw = 1; cycle();
    clear_pulses(); nbr = 7'b1000000; cycle(); idle(1);

    // R5: deferred until rollover
    tag = "R5";
    rsy = 1; nbr = 7'b0000001; cycle(); idle(3);
    roll = 1; cycle(); idle(2);
    // R11: boundary with nothing pending
    tag = "R11";
    roll = 1; cycle(); idle(1);
    // R7: merge
    tag = "R7";
    sw = 1; cycle(); clear_pulses(); nbr = 7'b0100100; cycle();
    clear_pulses(); sw = 1; nbr = 7'b0000010; cycle(); idle(1);
    roll = 1; cycle(); idle(2);
    // R6: gating nonzero makes resync ignored
    tag = "R6";
    gate = 4'b0101; sw = 1; cycle(); idle(1);
    gate = 4'b1000; nbr = 7'b0010000; cycle(); idle(1);
    gate = 0;
    // R8: sync reset releases pending
    tag = "R8";
    run = 1; ren = 1; sw = 1; cycle(); idle(2);
    evt = 1; cycle(); idle(2);
    // R9: request at boundary
    tag = "R9";
    sw = 1; roll = 1; cycle(); idle(1);
    roll = 1; cycle(); idle(1);
    // R10: reset clears pending
    tag = "R10";
    nbr = 7'b0000001; cycle(); clear_pulses();
    rst_n = 0; cycle(); cycle();
    rst_n = 1; cycle();
    roll = 1; cycle(); idle(1);

    // mixed traffic
    tag = "R4/R5 mix";
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evt  = lfsr[0] & lfsr[5];
      sen  = lfsr[1];
      ren  = lfsr[2];
      run  = lfsr[3];
      roll = lfsr[4] & lfsr[9] & lfsr[11];
      rsy  = lfsr[6] | lfsr[14];
      gate = (lfsr[7] & lfsr[8]) ? lfsr[15:12] : 4'd0;
      sw   = lfsr[10] & lfsr[13] & lfsr[2];
      nbr  = (lfsr[11] & lfsr[1]) ? lfsr[6:0] : 7'd0;
      cycle();
    end
    idle(2);
    finish_run();
  end
endmodule